// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one byte at a time over a four-wire serial link. A host loads a byte into a single buffer register. If the engine is idle, that load starts an exchange. The byte leaves most-significant bit first on the data output while eight incoming bits are gathered from the data input. When the exchange ends, the received byte replaces the contents of the buffer and a buffer-full flag rises. Reading the buffer clears the flag. A load while an exchange is running is discarded and raises a sticky collision flag, which stays set until the host clears it.

As a master, the engine generates the serial clock from the system clock. Each clock half-period lasts a programmable number of system cycles, with a minimum of two. The engine drives an active-low chip select for the whole exchange. Three settings shape the timing:
- Clock polarity sets the idle level of the serial clock.
- Edge select picks which clock edge launches data.
- A late-sample option moves input capture from the middle of each bit to its end.

As a slave, the engine takes the serial clock and an active-low select from outside, passes both through synchronisers, and always captures in mid-bit. In slave mode the late-sample option is forced off.

The control flow has five states:
- IDLE waits for a load. It goes to M_LEAD in master mode and to S_ACTIVE in slave mode.
- M_LEAD is the first half of a master bit. It always goes on to M_TRAIL.
- M_TRAIL is the second half of a master bit. It goes back to M_LEAD for the next bit, or to DONE after the last bit.
- S_ACTIVE follows the external clock. It goes to DONE on the eighth capture edge.
- DONE lasts one cycle. It writes the received byte into the buffer and returns to IDLE.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, buf_full_o, wcol_o and busy_o are 0, cs_n_o is 1 and sck_o equals cpol_i.
- R2: A load in master mode while idle drives cs_n_o low for exactly 16*H system cycles, where H is the clamped half-period. sck_o makes exactly 16 transitions and then rests at cpol_i. cs_n_o is low only while busy_o is 1, and sck_o equals cpol_i whenever busy_o is 0.
- R3: Data leaves sdo_o most-significant bit first. sdo_o changes only on the launch edge. The launch edge is rising when cpol_i XOR cke_i is 1 (cpol 0 with cke 1, or cpol 1 with cke 0) and falling otherwise. During the first half of every bit, sck_o sits at the level reached by the launch edge.
- R4: In master mode with late_smp_i at 0, sdi_i is captured in the last system cycle of each bit's first half.
- R5: In master mode with late_smp_i at 1, sdi_i is captured in the last system cycle of each bit's second half.
- R6: On completion the received byte appears on rd_data_o and buf_full_o goes to 1. A rd_en_i pulse clears buf_full_o. If completion and a read fall in the same cycle, buf_full_o stays 1.
- R7: A load while busy_o is 1 leaves the transfer and rd_data_o unchanged and sets wcol_o. wcol_o stays set until a wcol_clr_i pulse clears it. A new collision in the same cycle as the clear keeps it set.
- R8: In slave mode the engine captures sdi_i on the non-launch edge of slv_sck_i, whatever late_smp_i says. sdo_o presents the loaded byte MSB first and advances on each launch edge that follows a capture. During a slave exchange cs_n_o stays 1 and sck_o stays at cpol_i.
- R9: In slave mode, slv_sck_i edges that arrive while slv_sel_n_i is 1 are ignored.
- R10: A half_div_i value below 2 acts as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cke_i | input | 1 | Launch edge select, combined with cpol_i |
| late_smp_i | input | 1 | Master capture at end of bit instead of mid-bit |
| slave_i | input | 1 | 1 selects slave mode |
| half_div_i | input | DIV_W | System cycles per serial clock half-period |
| wr_en_i | input | 1 | Load strobe for the buffer |
| wr_data_i | input | DATA_W | Byte to transmit |
| rd_en_i | input | 1 | Read strobe that clears buffer-full |
| wcol_clr_i | input | 1 | Clears the collision flag |
| rd_data_o | output | DATA_W | Buffer contents |
| buf_full_o | output | 1 | New received byte waiting |
| wcol_o | output | 1 | Sticky write-collision flag |
| busy_o | output | 1 | Exchange in progress |
| sck_o | output | 1 | Master serial clock |
| sdo_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Master chip select, active low |
| sdi_i | input | 1 | Serial data in |
| slv_sck_i | input | 1 | Serial clock in slave mode |
| slv_sel_n_i | input | 1 | Slave select in slave mode, active low |

## Verification
In master exchanges, the input line carries one byte during the first half of every bit and a different byte during the second half. The received value therefore shows which capture point was used, and it tells the mid-bit setting apart from the end-of-bit setting. Random polarity, edge and divider settings are mixed with directed runs. These include half-periods of 0 and 1, a load in the middle of an exchange, and a read that lands on the completion cycle. Slave exchanges run in all four polarity/edge combinations with the late-sample option set. Before each slave exchange, a burst of clock edges is sent while the slave is deselected; a design that fails to ignore those edges either finishes early or receives a shifted byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LEAD,
        ST_M_TRAIL,
        ST_S_ACTIVE,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic cpol;
        logic cke;
        logic late;
        logic slave;
    } eng_cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
// Counts system cycles inside one serial-clock half period.
module spi_half_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == half - ONE);
    assign last   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_end ? '0 : cnt_q + ONE;
        end
    end
endmodule

// File: rtl/spi_edge_sync.sv
// Multi-stage synchroniser for slave-side inputs, with one extra stage kept for edge detection.
module spi_edge_sync #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    input  logic [N-1:0] reset_val,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    logic [STAGES:0][N-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES+1){reset_val}};
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_i};
        end
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/spi_shifter.sv
// Separate transmit and receive shift registers, MSB first.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tx_adv,
    input  logic         rx_cap,
    input  logic         rx_bit,
    output logic         msb,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (tx_adv) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (rx_cap) begin
            rx_q <= {rx_q[W-2:0], rx_bit};
        end
    end

    assign msb     = tx_q[W-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol_i,
    input  logic              cke_i,
    input  logic              late_smp_i,
    input  logic              slave_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              wcol_clr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              buf_full_o,
    output logic              wcol_o,
    output logic              busy_o,
    output logic              sck_o,
    output logic              sdo_o,
    output logic              cs_n_o,
    input  logic              sdi_i,
    input  logic              slv_sck_i,
    input  logic              slv_sel_n_i
);
    localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
    localparam int SYNC_N   = 3;

    eng_state_e        state_q, state_d;
    eng_cfg_t          cfg_q;
    logic [DIV_W-1:0]  half_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] buf_q;
    logic              full_q;
    logic              wcol_q;

    logic              start;
    logic              half_last;
    logic              run_timer;
    logic              lead_lvl;
    logic              tx_adv, rx_cap, rx_bit;
    logic              msb;
    logic [DATA_W-1:0] rx_word;

    logic [SYNC_N-1:0] sync_v, prev_v;
    logic              s_sck, p_sck, s_sel_n, s_sdi;
    logic              s_edge, s_tx_edge, s_smp_edge;

    // Clock level reached by the launch edge; it is held during the first half of each bit.
    assign lead_lvl  = cfg_q.cpol ^ cfg_q.cke;
    assign start     = wr_en_i && (state_q == ST_IDLE);
    assign run_timer = (state_q == ST_M_LEAD) || (state_q == ST_M_TRAIL);

    spi_half_timer #(.CW(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (run_timer),
        .half    (half_q),
        .last    (half_last)
    );

    spi_edge_sync #(.STAGES(SYNC_STAGES), .N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   ({slv_sck_i, slv_sel_n_i, sdi_i}),
        .reset_val (3'b010),
        .sync_o    (sync_v),
        .prev_o    (prev_v)
    );

    assign s_sck      = sync_v[2];
    assign s_sel_n    = sync_v[1];
    assign s_sdi      = sync_v[0];
    assign p_sck      = prev_v[2];
    assign s_edge     = (s_sck != p_sck) && !s_sel_n;
    assign s_tx_edge  = s_edge && (s_sck == lead_lvl);
    assign s_smp_edge = s_edge && (s_sck != lead_lvl);

    spi_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (wr_data_i),
        .tx_adv   (tx_adv),
        .rx_cap   (rx_cap),
        .rx_bit   (rx_bit),
        .msb      (msb),
        .rx_word  (rx_word)
    );

    // Next state and shift control.
    always_comb begin
        state_d = state_q;
        tx_adv  = 1'b0;
        rx_cap  = 1'b0;
        rx_bit  = sdi_i;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en_i) begin
                    state_d = slave_i ? ST_S_ACTIVE : ST_M_LEAD;
                end
            end
            ST_M_LEAD: begin
                if (half_last) begin
                    state_d = ST_M_TRAIL;
                    rx_cap  = !cfg_q.late;
                end
            end
            ST_M_TRAIL: begin
                if (half_last) begin
                    rx_cap = cfg_q.late;
                    if (bit_q == LAST_BIT) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_M_LEAD;
                        tx_adv  = 1'b1;
                    end
                end
            end
            ST_S_ACTIVE: begin
                rx_bit = s_sdi;
                rx_cap = s_smp_edge;
                tx_adv = s_tx_edge && (bit_q != '0);
                if (s_smp_edge && (bit_q == LAST_BIT)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Configuration latched at start, plus the bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            half_q <= MIN_HALF;
            bit_q  <= '0;
        end else if (start) begin
            cfg_q.cpol  <= cpol_i;
            cfg_q.cke   <= cke_i;
            cfg_q.late  <= late_smp_i && !slave_i;
            cfg_q.slave <= slave_i;
            half_q      <= (half_div_i < MIN_HALF) ? MIN_HALF : half_div_i;
            bit_q       <= '0;
        end else if (state_q == ST_M_TRAIL && half_last && bit_q != LAST_BIT) begin
            bit_q <= bit_q + 1'b1;
        end else if (state_q == ST_S_ACTIVE) begin
            if (s_sel_n) begin
                bit_q <= '0;
            end else if (s_smp_edge) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Buffer and status flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (start) begin
                buf_q <= wr_data_i;
            end else if (state_q == ST_DONE) begin
                buf_q <= rx_word;
            end
            if (state_q == ST_DONE) begin
                full_q <= 1'b1;
            end else if (rd_en_i) begin
                full_q <= 1'b0;
            end
            if (wr_en_i && state_q != ST_IDLE) begin
                wcol_q <= 1'b1;
            end else if (wcol_clr_i) begin
                wcol_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        cs_n_o = 1'b1;
        sck_o  = cpol_i;
        unique case (state_q)
            ST_M_LEAD: begin
                cs_n_o = 1'b0;
                sck_o  = lead_lvl;
            end
            ST_M_TRAIL: begin
                cs_n_o = 1'b0;
                sck_o  = !lead_lvl;
            end
            default: begin
            end
        endcase
    end

    assign sdo_o      = msb;
    assign rd_data_o  = buf_q;
    assign buf_full_o = full_q;
    assign wcol_o     = wcol_q;
endmodule

// File: rtl/spi_engine_checker.sv
module spi_engine_checker
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              wcol_clr_i,
    input logic              cpol_i,
    input logic              busy_o,
    input logic              cs_n_o,
    input logic              sck_o,
    input logic              buf_full_o,
    input logic              wcol_o,
    input logic [DATA_W-1:0] rd_data_o,
    input eng_state_e        state
);
    // R2: chip select is asserted only during an exchange
    a_r2_cs_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    // R2: the clock rests at the polarity level when idle
    a_r2_idle_sck_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sck_o == cpol_i));

    // R6: completion raises buffer-full
    a_r6_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> buf_full_o);

    // R6: a read with no completion pending clears buffer-full
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !busy_o) |=> !buf_full_o);

    // R7: a load during an exchange sets the collision flag
    a_r7_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && busy_o) |=> wcol_o);

    // R7: the collision flag holds until cleared
    a_r7_wcol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_o && !wcol_clr_i) |=> wcol_o);

    // R7: a colliding load leaves the buffer untouched
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && busy_o && state != ST_DONE) |=> $stable(rd_data_o));

    // R8: in slave mode the master pins stay passive
    a_r8_slave_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S_ACTIVE) |-> (cs_n_o && sck_o == cpol_i));
endmodule

bind spi_shift_engine spi_engine_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .wcol_clr_i (wcol_clr_i),
    .cpol_i     (cpol_i),
    .busy_o     (busy_o),
    .cs_n_o     (cs_n_o),
    .sck_o      (sck_o),
    .buf_full_o (buf_full_o),
    .wcol_o     (wcol_o),
    .rd_data_o  (rd_data_o),
    .state      (state_q)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cke = 1'b0, late = 1'b0, slave = 1'b0;
    logic [7:0] half_div = 8'd2;
    logic       wr_en = 1'b0, rd_en = 1'b0, wcol_clr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       buf_full, wcol, busy, sck_o, sdo, cs_n;
    logic       sdi = 1'b0, sck_i = 1'b0, ss_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    spi_shift_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .cke_i(cke), .late_smp_i(late),
        .slave_i(slave), .half_div_i(half_div), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .wcol_clr_i(wcol_clr), .rd_data_o(rd_data), .buf_full_o(buf_full),
        .wcol_o(wcol), .busy_o(busy), .sck_o(sck_o), .sdo_o(sdo), .cs_n_o(cs_n),
        .sdi_i(sdi), .slv_sck_i(sck_i), .slv_sel_n_i(ss_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic lead_level(input logic p, input logic e);
        return p ^ e;
    endfunction

    function automatic int exp_low_cycles(input int h);
        return 16 * ((h < 2) ? 2 : h);
    endfunction

    function automatic logic [7:0] exp_rx(input logic [7:0] da, input logic [7:0] db,
                                          input logic s, input logic slv);
        return (s && !slv) ? db : da;
    endfunction

    task automatic read_clear(input string tag);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        chk(buf_full === 1'b0, tag, "buf_full after read", buf_full, 0);
    endtask

    task automatic run_master(input logic [7:0] tx, input logic [7:0] da, input logic [7:0] db,
                              input logic p, input logic e, input logic s, input int h,
                              input bit collide, input bit race_rd);
        logic a_lvl, prev_sck, prev_sdo, prev_cs, first_lvl;
        logic [7:0] got;
        int low_cyc, edges, mids, viol, guard;
        a_lvl = lead_level(p, e);
        @(negedge clk);
        cpol = p; cke = e; late = s; slave = 1'b0; half_div = h[7:0];
        @(negedge clk);
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        first_lvl = sck_o;
        prev_sck = p; prev_sdo = sdo; prev_cs = 1'b1;
        low_cyc = 0; edges = 0; mids = 0; viol = 0; guard = 0; got = 8'h00;
        while (busy === 1'b1 && guard < 2000) begin
            if (sck_o !== prev_sck) edges++;
            if (cs_n === 1'b0) begin
                low_cyc++;
                if (prev_sck === a_lvl && sck_o === !a_lvl) mids++;
                if (!prev_cs && sdo !== prev_sdo && !(prev_sck !== a_lvl && sck_o === a_lvl)) viol++;
                if (sck_o === a_lvl) begin
                    got[7-mids] = sdo;
                    sdi = da[7-mids];
                end else begin
                    sdi = db[8-mids];
                end
            end
            if (collide && low_cyc == 3 * ((h < 2) ? 2 : h)) begin
                wr_data = ~tx; wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            if (race_rd && cs_n === 1'b1 && low_cyc > 0) rd_en = 1'b1;
            prev_sck = sck_o; prev_sdo = sdo; prev_cs = cs_n;
            @(negedge clk);
            guard++;
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk(guard < 2000, "R2", "transfer ended", guard, 0);
        chk(first_lvl === a_lvl, "R3", "first-half clock level", first_lvl, a_lvl);
        chk(got === tx, "R3", "MSB-first data out", got, tx);
        chk(viol == 0, "R3", "data changes off launch edge", viol, 0);
        chk(edges == 16, "R2", "clock transitions", edges, 16);
        chk(low_cyc == exp_low_cycles(h), (h < 2) ? "R10" : "R2", "select low cycles",
            low_cyc, exp_low_cycles(h));
        chk(sck_o === p && cs_n === 1'b1, "R2", "idle after transfer", sck_o, p);
        chk(rd_data === exp_rx(da, db, s, 1'b0), s ? "R5" : "R4", "received byte",
            rd_data, exp_rx(da, db, s, 1'b0));
        chk(buf_full === 1'b1, race_rd ? "R6" : "R6", "buf_full on completion", buf_full, 1);
        if (collide) begin
            chk(wcol === 1'b1, "R7", "collision flag set", wcol, 1);
            @(negedge clk);
            chk(wcol === 1'b1, "R7", "collision flag sticky", wcol, 1);
            wcol_clr = 1'b1;
            @(negedge clk) wcol_clr = 1'b0;
            chk(wcol === 1'b0, "R7", "collision flag cleared", wcol, 0);
        end
        read_clear("R6");
    endtask

    task automatic run_slave(input logic [7:0] tx, input logic [7:0] mosi,
                             input logic p, input logic e, input logic s);
        logic a_lvl;
        logic [7:0] got;
        bit quiet_bad;
        int hs;
        hs = 8;
        quiet_bad = 1'b0;
        got = 8'h00;
        a_lvl = lead_level(p, e);
        @(negedge clk);
        cpol = p; cke = e; late = s; slave = 1'b1; sck_i = p; ss_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        repeat (9) begin
            sck_i = !sck_i; repeat (hs) @(negedge clk);
            sck_i = !sck_i; repeat (hs) @(negedge clk);
        end
        chk(busy === 1'b1 && buf_full === 1'b0, "R9", "edges while deselected ignored",
            {busy, buf_full}, 2'b10);
        ss_n = 1'b0;
        repeat (hs) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (sck_i !== a_lvl) sck_i = a_lvl;
            sdi = mosi[7-k];
            repeat (hs) @(negedge clk);
            got[7-k] = sdo;
            if (cs_n !== 1'b1 || sck_o !== p) quiet_bad = 1'b1;
            sck_i = !a_lvl;
            repeat (hs) @(negedge clk);
        end
        sck_i = p;
        repeat (hs) @(negedge clk);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(got === tx, "R8", "slave data out", got, tx);
        chk(!quiet_bad, "R8", "master pins quiet in slave mode", quiet_bad, 0);
        chk(busy === 1'b0 && buf_full === 1'b1, "R8", "slave completion", {busy, buf_full}, 2'b01);
        chk(rd_data === exp_rx(mosi, ~mosi, s, 1'b1), "R8", "slave received byte",
            rd_data, exp_rx(mosi, ~mosi, s, 1'b1));
        read_clear("R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && cs_n === 1'b1, "R1", "busy/cs during reset", {busy, cs_n}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(buf_full === 1'b0, "R1", "buf_full after reset", buf_full, 0);
        chk(wcol === 1'b0, "R1", "wcol after reset", wcol, 0);
        chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
        chk(cs_n === 1'b1, "R1", "cs_n after reset", cs_n, 1);
        chk(sck_o === cpol, "R1", "sck idle after reset", sck_o, cpol);

        // Directed: every polarity/edge pair with both capture points.
        for (int m = 0; m < 8; m++) begin
            run_master(8'hA5 ^ 8'(m), 8'h3C, 8'hC3, m[0], m[1], m[2], 2, 0, 0);
        end
        // R10: clamped half-period values.
        run_master(8'h81, 8'hF0, 8'h0F, 1'b0, 1'b1, 1'b0, 1, 0, 0);
        run_master(8'h7E, 8'h55, 8'hAA, 1'b1, 1'b0, 1'b1, 0, 0, 0);
        // R7: collision mid-transfer.
        run_master(8'h96, 8'h12, 8'h34, 1'b0, 1'b0, 1'b1, 3, 1, 0);
        // R6: read on the completion cycle.
        run_master(8'h4B, 8'hE7, 8'h18, 1'b1, 1'b1, 1'b0, 2, 0, 1);
        // Random master exchanges.
        for (int i = 0; i < 14; i++) begin
            run_master(8'($urandom), 8'($urandom), 8'($urandom),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), 2 + $urandom_range(0, 3), 0, 0);
        end
        // Slave exchanges with late sampling requested (must be ignored).
        for (int m = 0; m < 4; m++) begin
            run_slave(8'hD2 ^ 8'(m * 17), 8'h6B ^ 8'(m * 9), m[0], m[1], 1'b1);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule